// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block supplies the byte that a flash memory returns on its data bus while an internal program or erase is running, after such an operation has overrun its time limit, or while a sector erase is suspended. A command decoder starts an operation with a one-cycle `start_i` pulse. The pulse carries the operation kind, the target sector, the new byte, the byte already stored there, the erase selection and the per-sector protection mask. The array engine reports completion on `core_done_i`. For every read, the host-side multiplexer asks the block for either a status byte or a pass-through request (`pass_o`), in which case the multiplexer returns array data.

Two toggle bits change on read strobes only, never on a clock. Bit 6 flips on every read while an operation is active, so the host can detect busy by reading twice. Bit 2 flips only on reads that hit a sector selected for erase, so the host can tell which sector is erasing. Together they tell active erase from suspended erase. The block holds one shared cycle counter. The counter limits the run time, and it also times the short fake runs that follow a request aimed at protected sectors. When the run time is exceeded, the block reports failure on bit 5 until it receives a reset command.

The state machine has these states.
- ST_IDLE: accepts a start.
- ST_PRUN: a program is running. It returns to ST_IDLE on a legal completion, or moves to ST_FAIL on timeout.
- ST_PPROT: a program aimed at a protected sector. It returns to ST_IDLE after the protected-program time.
- ST_ERUN: an erase is running. It returns to ST_IDLE on completion, moves to ST_SUSP on a suspend during a sector erase, or moves to ST_FAIL on timeout.
- ST_EPROT: an erase in which every selected sector is protected. It returns to ST_IDLE after the protected-erase time.
- ST_SUSP: a suspended sector erase. It returns to ST_ERUN on a resume.
- ST_FAIL: the time limit was exceeded. It returns to ST_IDLE on a reset command.

Top module: `flash_status_gen`

## Requirements
- R1: In ST_PRUN and ST_PPROT a read returns a status byte whose bit 7 is the inverse of bit 7 of the new byte, and `pass_o` is 0. The status byte holds bit 7 (poll), bit 6 (toggle), bit 5 (timeout) and bit 2 (sector toggle), and all other bits are 0. A `core_done_i` pulse during a legal program returns the block to ST_IDLE, where `pass_o` is 1.
- R2: While an erase runs, bit 7 reads 0. In ST_SUSP, a read of a selected sector returns bit 7 = 1. After `core_done_i`, reads pass through.
- R3: Bit 6 is 0 at the first read after a start. It inverts on every read strobe in ST_PRUN, ST_PPROT, ST_ERUN, ST_EPROT and ST_FAIL.
- R4: Bit 6 holds its value through reads in ST_SUSP. Bit 2 inverts on each read of a sector selected for erase, whether the erase is active or suspended. Bit 2 is unchanged by a read of any other sector.
- R5: In ST_SUSP, a read of a sector not selected for erase gives `pass_o` = 1.
- R6: After TIMEOUT_CYC cycles in a run state without a completion, the block enters ST_FAIL and bit 5 reads 1. Bit 5 stays 1 until `clear_i`, which returns the block to ST_IDLE.
- R7: A program to a sector whose `prot_i` bit is set shows program status for PROT_PROG_CYC cycles and then returns to pass-through. It ignores `core_done_i`.
- R8: An erase whose selected sectors are all protected shows erase status for PROT_ERASE_CYC cycles and then returns to pass-through. A chip erase selects all sectors. A sector erase selects the sectors set in `erase_sel_i`, where bit i is sector i.
- R9: `merged_o` equals the old byte ANDed with the new byte. A program that tries to turn any 0 bit into 1 ignores `core_done_i` and ends in the timeout.
- R10: A suspend is honoured only in ST_ERUN of a sector erase. It is ignored during a program or a chip erase. The run-time counter does not advance in ST_SUSP.
- R11: `clear_i` has no effect while an operation runs. It only leaves ST_FAIL.
- R12: After reset, and in ST_IDLE, `pass_o` is 1 and `rd_data_o` is 0. The kind codes are 0 program, 1 sector erase and 2 chip erase. Kind code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle operation start |
| kind_i | input | 2 | Operation kind: 0 program, 1 sector erase, 2 chip erase |
| op_sec_i | input | SECW | Sector targeted by a program |
| new_byte_i | input | 8 | Byte being programmed |
| old_byte_i | input | 8 | Byte currently stored at the target |
| erase_sel_i | input | NSEC | Sectors selected for a sector erase |
| prot_i | input | NSEC | Per-sector protection |
| core_done_i | input | 1 | Array engine finished |
| suspend_i | input | 1 | Erase suspend command |
| resume_i | input | 1 | Erase resume command |
| clear_i | input | 1 | Reset command |
| rd_stb_i | input | 1 | One-cycle read strobe |
| rd_sec_i | input | SECW | Sector of the read address |
| rd_data_o | output | 8 | Status byte |
| pass_o | output | 1 | Return array data instead of status |
| merged_o | output | 8 | Byte the array should store |

## Verification
On every cycle, the assertions check several invariants. The poll bit in ST_PRUN is the inverse of bit 7 of the new byte, and it is 0 in ST_ERUN. Bit 6 flips on each active read and holds during a suspend. Neither toggle moves without a read strobe. Non-selected reads pass through in ST_SUSP. The failure state stays sticky until clear. A program that tries to set a bit is never completed, and the counter stays within its bound. Some properties span many cycles or whole command sequences, and only the bench scenarios show them. These are the exact timeout and protected-run durations, the counter pausing through a long suspend, a suspend ignored during a chip erase, and the kind code 3 being ignored.

// File: rtl/flsts_pkg.sv
package flsts_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRUN  = 3'd1,
        ST_PPROT = 3'd2,
        ST_ERUN  = 3'd3,
        ST_EPROT = 3'd4,
        ST_SUSP  = 3'd5,
        ST_FAIL  = 3'd6
    } st_e;

    localparam logic [1:0] OP_PROG   = 2'd0;
    localparam logic [1:0] OP_SERASE = 2'd1;
    localparam logic [1:0] OP_CERASE = 2'd2;
endpackage

// File: rtl/fsts_seq.sv
module fsts_seq
    import flsts_pkg::*;
#(
    parameter int NSEC           = 8,
    parameter int TIMEOUT_CYC    = 64,
    parameter int PROT_PROG_CYC  = 8,
    parameter int PROT_ERASE_CYC = 16,
    localparam int SECW = $clog2(NSEC),
    localparam int MAXP = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC,
    localparam int MAXC = (TIMEOUT_CYC > MAXP) ? TIMEOUT_CYC : MAXP,
    localparam int CNTW = $clog2(MAXC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      kind_i,
    input  logic [SECW-1:0] op_sec_i,
    input  logic [7:0]      new_byte_i,
    input  logic [7:0]      old_byte_i,
    input  logic [NSEC-1:0] erase_sel_i,
    input  logic [NSEC-1:0] prot_i,
    input  logic            core_done_i,
    input  logic            suspend_i,
    input  logic            resume_i,
    input  logic            clear_i,
    output st_e             state_o,
    output logic            accept_o,
    output logic            is_erase_o,
    output logic [NSEC-1:0] sel_o,
    output logic [7:0]      new_o,
    output logic [7:0]      merged_o,
    output logic [CNTW-1:0] cnt_o
);
    localparam logic [CNTW-1:0] TO_LAST = CNTW'(TIMEOUT_CYC - 1);
    localparam logic [CNTW-1:0] PP_LAST = CNTW'(PROT_PROG_CYC - 1);
    localparam logic [CNTW-1:0] PE_LAST = CNTW'(PROT_ERASE_CYC - 1);

    st_e             state_q, state_d;
    logic [CNTW-1:0] cnt_q;
    logic [7:0]      new_q, old_q;
    logic [NSEC-1:0] sel_q, sel_d;
    logic            erase_q, sect_erase_q, conflict_q;
    logic            accept, cnt_en;

    assign accept = (state_q == ST_IDLE) && start_i && (kind_i != 2'd3);

    always_comb begin
        unique case (kind_i)
            OP_SERASE: sel_d = erase_sel_i;
            OP_CERASE: sel_d = '1;
            default:   sel_d = '0;
        endcase
    end

    assign cnt_en = (state_q == ST_PRUN) || (state_q == ST_PPROT) ||
                    (state_q == ST_ERUN) || (state_q == ST_EPROT);

    // state register and operation latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            new_q        <= '0;
            old_q        <= '0;
            sel_q        <= '0;
            erase_q      <= 1'b0;
            sect_erase_q <= 1'b0;
            conflict_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q        <= '0;
                new_q        <= new_byte_i;
                old_q        <= old_byte_i;
                sel_q        <= sel_d;
                erase_q      <= (kind_i != OP_PROG);
                sect_erase_q <= (kind_i == OP_SERASE);
                conflict_q   <= (kind_i == OP_PROG) && (|(new_byte_i & ~old_byte_i));
            end else if (cnt_en && (cnt_q != CNTW'(MAXC))) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (kind_i == OP_PROG)
                        state_d = prot_i[op_sec_i] ? ST_PPROT : ST_PRUN;
                    else
                        state_d = ((sel_d & ~prot_i) == '0) ? ST_EPROT : ST_ERUN;
                end
            end
            ST_PRUN: begin
                if (core_done_i && !conflict_q) state_d = ST_IDLE;
                else if (cnt_q == TO_LAST)      state_d = ST_FAIL;
            end
            ST_PPROT: begin
                if (cnt_q == PP_LAST) state_d = ST_IDLE;
            end
            ST_ERUN: begin
                if (core_done_i)                     state_d = ST_IDLE;
                else if (suspend_i && sect_erase_q)  state_d = ST_SUSP;
                else if (cnt_q == TO_LAST)           state_d = ST_FAIL;
            end
            ST_EPROT: begin
                if (cnt_q == PE_LAST) state_d = ST_IDLE;
            end
            ST_SUSP: begin
                if (resume_i) state_d = ST_ERUN;
            end
            ST_FAIL: begin
                if (clear_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        state_o    = state_q;
        accept_o   = accept;
        is_erase_o = erase_q;
        sel_o      = sel_q;
        new_o      = new_q;
        merged_o   = old_q & new_q;
        cnt_o      = cnt_q;
    end
endmodule

// File: rtl/fsts_tog.sv
module fsts_tog #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_cell
        logic q_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q_r <= 1'b0;
            else if (clr_i)    q_r <= 1'b0;
            else if (en_i[g])  q_r <= ~q_r;
        end
        assign q_o[g] = q_r;
    end
endmodule

// File: rtl/fsts_out.sv
module fsts_out
    import flsts_pkg::*;
(
    input  st_e        state_i,
    input  logic       is_erase_i,
    input  logic       new7_i,
    input  logic       hit_i,
    input  logic       tog6_i,
    input  logic       tog2_i,
    output logic [7:0] rd_data_o,
    output logic       pass_o
);
    always_comb begin
        rd_data_o = 8'h00;
        pass_o    = 1'b0;
        unique case (state_i)
            ST_IDLE: pass_o = 1'b1;
            ST_PRUN, ST_PPROT:
                rd_data_o = {~new7_i, tog6_i, 1'b0, 2'b00, 1'b0, 2'b00};
            ST_ERUN, ST_EPROT:
                rd_data_o = {1'b0, tog6_i, 1'b0, 2'b00, tog2_i, 2'b00};
            ST_SUSP: begin
                if (hit_i) rd_data_o = {1'b1, tog6_i, 1'b0, 2'b00, tog2_i, 2'b00};
                else       pass_o    = 1'b1;
            end
            ST_FAIL:
                rd_data_o = {is_erase_i ? 1'b0 : ~new7_i, tog6_i, 1'b1, 2'b00,
                             is_erase_i & tog2_i, 2'b00};
            default: pass_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flsts_pkg::*;
#(
    parameter int NSEC           = 8,
    parameter int TIMEOUT_CYC    = 64,
    parameter int PROT_PROG_CYC  = 8,
    parameter int PROT_ERASE_CYC = 16,
    localparam int SECW = $clog2(NSEC),
    localparam int MAXP = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC,
    localparam int MAXC = (TIMEOUT_CYC > MAXP) ? TIMEOUT_CYC : MAXP,
    localparam int CNTW = $clog2(MAXC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      kind_i,
    input  logic [SECW-1:0] op_sec_i,
    input  logic [7:0]      new_byte_i,
    input  logic [7:0]      old_byte_i,
    input  logic [NSEC-1:0] erase_sel_i,
    input  logic [NSEC-1:0] prot_i,
    input  logic            core_done_i,
    input  logic            suspend_i,
    input  logic            resume_i,
    input  logic            clear_i,
    input  logic            rd_stb_i,
    input  logic [SECW-1:0] rd_sec_i,
    output logic [7:0]      rd_data_o,
    output logic            pass_o,
    output logic [7:0]      merged_o
);
    st_e             state_w;
    logic            accept_w, erase_w, hit_w, act6_w, act2_w;
    logic [NSEC-1:0] sel_w;
    logic [7:0]      new_w;
    logic [CNTW-1:0] cnt_w;
    logic [1:0]      tog_w;

    fsts_seq #(
        .NSEC(NSEC), .TIMEOUT_CYC(TIMEOUT_CYC),
        .PROT_PROG_CYC(PROT_PROG_CYC), .PROT_ERASE_CYC(PROT_ERASE_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
        .op_sec_i(op_sec_i), .new_byte_i(new_byte_i), .old_byte_i(old_byte_i),
        .erase_sel_i(erase_sel_i), .prot_i(prot_i), .core_done_i(core_done_i),
        .suspend_i(suspend_i), .resume_i(resume_i), .clear_i(clear_i),
        .state_o(state_w), .accept_o(accept_w), .is_erase_o(erase_w),
        .sel_o(sel_w), .new_o(new_w), .merged_o(merged_o), .cnt_o(cnt_w)
    );

    assign hit_w  = sel_w[rd_sec_i];
    assign act6_w = (state_w == ST_PRUN) || (state_w == ST_PPROT) ||
                    (state_w == ST_ERUN) || (state_w == ST_EPROT) ||
                    (state_w == ST_FAIL);
    assign act2_w = hit_w && (state_w != ST_IDLE);

    fsts_tog #(.N(2)) u_tog (
        .clk(clk), .rst_n(rst_n), .clr_i(accept_w),
        .en_i({rd_stb_i & act2_w, rd_stb_i & act6_w}),
        .q_o(tog_w)
    );

    fsts_out u_out (
        .state_i(state_w), .is_erase_i(erase_w), .new7_i(new_w[7]),
        .hit_i(hit_w), .tog6_i(tog_w[0]), .tog2_i(tog_w[1]),
        .rd_data_o(rd_data_o), .pass_o(pass_o)
    );
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk
    import flsts_pkg::*;
#(
    parameter int NSEC        = 8,
    parameter int TIMEOUT_CYC = 64,
    parameter int CNTW        = 7,
    localparam int SECW = $clog2(NSEC)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            core_done_i,
    input logic            clear_i,
    input logic            rd_stb_i,
    input logic [SECW-1:0] rd_sec_i,
    input logic [7:0]      rd_data_o,
    input logic            pass_o,
    input logic [7:0]      merged_o,
    input st_e             state_w,
    input logic [NSEC-1:0] sel_w,
    input logic [7:0]      new_w,
    input logic [CNTW-1:0] cnt_w,
    input logic [1:0]      tog_w
);
    logic active6;
    assign active6 = (state_w == ST_PRUN) || (state_w == ST_PPROT) ||
                     (state_w == ST_ERUN) || (state_w == ST_EPROT) ||
                     (state_w == ST_FAIL);

    // R1
    prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_PRUN) |-> (rd_data_o[7] != new_w[7]) && !pass_o);

    // R2
    erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_ERUN) |-> !rd_data_o[7] && !pass_o);

    // R3
    tog6_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && active6) |=> (tog_w[0] != $past(tog_w[0])));

    // R4
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb_i && !(state_w == ST_IDLE && start_i)) |=> ($stable(tog_w)));

    // R4
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_SUSP) |=> $stable(tog_w[0]));

    // R5
    susp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_SUSP && !sel_w[rd_sec_i]) |-> pass_o);

    // R6
    sticky_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_FAIL && !clear_i) |=> (state_w == ST_FAIL) && rd_data_o[5]);

    // R9
    no_set_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_PRUN && core_done_i && merged_o != new_w) |=> (state_w != ST_IDLE));

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_PRUN || state_w == ST_ERUN) |-> (cnt_w < CNTW'(TIMEOUT_CYC)));
endmodule

bind flash_status_gen flash_status_gen_chk #(
    .NSEC(NSEC), .TIMEOUT_CYC(TIMEOUT_CYC), .CNTW(CNTW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .core_done_i(core_done_i),
    .clear_i(clear_i), .rd_stb_i(rd_stb_i), .rd_sec_i(rd_sec_i),
    .rd_data_o(rd_data_o), .pass_o(pass_o), .merged_o(merged_o),
    .state_w(state_w), .sel_w(sel_w), .new_w(new_w), .cnt_w(cnt_w), .tog_w(tog_w)
);

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
    localparam int NSEC = 8;
    localparam int TO   = 64;
    localparam int PP   = 8;
    localparam int PE   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 0, core_done_i = 0, suspend_i = 0, resume_i = 0, clear_i = 0, rd_stb_i = 0;
    logic [1:0] kind_i = 0;
    logic [2:0] op_sec_i = 0, rd_sec_i = 0;
    logic [7:0] new_byte_i = 0, old_byte_i = 0, erase_sel_i = 0, prot_i = 0;
    logic [7:0] rd_data_o, merged_o;
    logic       pass_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    flash_status_gen #(.NSEC(NSEC), .TIMEOUT_CYC(TO), .PROT_PROG_CYC(PP), .PROT_ERASE_CYC(PE))
    i_flash_status_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i), .op_sec_i(op_sec_i),
        .new_byte_i(new_byte_i), .old_byte_i(old_byte_i), .erase_sel_i(erase_sel_i),
        .prot_i(prot_i), .core_done_i(core_done_i), .suspend_i(suspend_i),
        .resume_i(resume_i), .clear_i(clear_i), .rd_stb_i(rd_stb_i), .rd_sec_i(rd_sec_i),
        .rd_data_o(rd_data_o), .pass_o(pass_o), .merged_o(merged_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !finished) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 50000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    typedef struct packed {
        logic [7:0] nb;
        logic [7:0] ob;
        logic [7:0] pr;
        logic [2:0] sec;
        logic [7:0] r0;
        logic [7:0] r1;
        logic [7:0] mrg;
        logic       dpass;
    } vec_t;

    localparam vec_t TAB [5] = '{
        '{8'h00, 8'hFF, 8'h00, 3'd0, 8'h80, 8'hC0, 8'h00, 1'b1},
        '{8'h80, 8'hFF, 8'h00, 3'd3, 8'h00, 8'h40, 8'h80, 1'b1},
        '{8'h5A, 8'hFF, 8'h01, 3'd7, 8'h80, 8'hC0, 8'h5A, 1'b1},
        '{8'h3C, 8'h0F, 8'h00, 3'd1, 8'h80, 8'hC0, 8'h0C, 1'b0},
        '{8'hF0, 8'hFF, 8'h04, 3'd2, 8'h00, 8'h40, 8'hF0, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_op(input logic [1:0] k, input logic [2:0] s, input logic [7:0] nb,
                            input logic [7:0] ob, input logic [7:0] sel, input logic [7:0] pr);
        kind_i = k; op_sec_i = s; new_byte_i = nb; old_byte_i = ob;
        erase_sel_i = sel; prot_i = pr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] d, output logic p);
        rd_stb_i = 1'b1; rd_sec_i = s;
        #1;
        d = rd_data_o; p = pass_o;
        @(negedge clk);
        rd_stb_i = 1'b0;
    endtask

    // 0 done, 1 suspend, 2 resume, 3 clear
    task automatic pulse(input int which);
        case (which)
            0: core_done_i = 1'b1;
            1: suspend_i = 1'b1;
            2: resume_i = 1'b1;
            default: clear_i = 1'b1;
        endcase
        @(negedge clk);
        core_done_i = 1'b0; suspend_i = 1'b0; resume_i = 1'b0; clear_i = 1'b0;
    endtask

    logic [7:0] d, d1;
    logic       p;

    initial begin
        @(negedge clk);
        #1;
        check("R12 reset pass", {7'd0, pass_o}, 8'h01);
        check("R12 reset data", rd_data_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);

        // program scenarios from the table (R1 R3 R7 R9)
        for (int i = 0; i < 5; i++) begin
            start_op(2'd0, TAB[i].sec, TAB[i].nb, TAB[i].ob, 8'h00, TAB[i].pr);
            check("R9 merged", merged_o, TAB[i].mrg);
            rd(3'd0, d, p);
            check("R1 R3 first read", d, TAB[i].r0);
            check("R1 busy pass", {7'd0, p}, 8'h00);
            rd(3'd0, d, p);
            check("R3 second read", d, TAB[i].r1);
            pulse(0);
            #1;
            check("R1 R7 R9 after done", {7'd0, pass_o}, {7'd0, TAB[i].dpass});
            wait_cyc(TO + 4);
            pulse(3);
            #1;
            check("R6 back to idle", {7'd0, pass_o}, 8'h01);
        end

        // timeout, sticky failure, ignored clear and suspend (R6 R10 R11)
        start_op(2'd0, 3'd0, 8'h00, 8'hFF, 8'h00, 8'h00);
        rd(3'd0, d, p);
        check("R6 no early timeout", d, 8'h80);
        pulse(3);
        rd(3'd0, d, p);
        check("R11 clear ignored while running", {p, d[6:0]}, 8'h40);
        pulse(1);
        rd(3'd0, d, p);
        check("R10 suspend ignored in program", {p, d[6:0]}, 8'h00);
        wait_cyc(TO + 4);
        rd(3'd0, d, p);
        check("R6 timeout bit", d & 8'hA0, 8'hA0);
        rd(3'd0, d1, p);
        check("R3 bit6 flips in fail", (d ^ d1) & 8'h40, 8'h40);
        wait_cyc(10);
        rd(3'd0, d, p);
        check("R6 bit5 sticky", d & 8'h20, 8'h20);
        pulse(3);
        #1;
        check("R6 clear leaves fail", {7'd0, pass_o}, 8'h01);

        // sector erase with suspend (R2 R4 R5 R10)
        start_op(2'd1, 3'd0, 8'h00, 8'h00, 8'h04, 8'h00);
        rd(3'd2, d, p);
        check("R2 R3 erase first read", d, 8'h00);
        rd(3'd2, d, p);
        check("R4 both toggles", d, 8'h44);
        rd(3'd5, d, p);
        check("R4 outside read", d, 8'h00);
        rd(3'd2, d, p);
        check("R4 bit2 unmoved by outside read", d, 8'h40);
        pulse(1);
        rd(3'd2, d, p);
        check("R2 suspended selected read", d, 8'h84);
        rd(3'd2, d, p);
        check("R4 bit6 steady in suspend", d, 8'h80);
        rd(3'd5, d, p);
        check("R5 unselected passes", {7'd0, p}, 8'h01);
        wait_cyc(TO + 10);
        rd(3'd2, d, p);
        check("R10 counter paused", d, 8'h84);
        pulse(2);
        rd(3'd2, d, p);
        check("R10 resume to erase", d, 8'h00);
        rd(3'd2, d, p);
        check("R4 toggles after resume", d, 8'h44);
        pulse(0);
        rd(3'd2, d, p);
        check("R2 done passes", {7'd0, p}, 8'h01);

        // chip erase ignores suspend (R10 R8)
        start_op(2'd2, 3'd0, 8'h00, 8'h00, 8'h00, 8'h01);
        pulse(1);
        rd(3'd0, d, p);
        check("R10 suspend ignored in chip erase", {p, d[6:0]} | {d[7], 7'd0}, 8'h00);
        pulse(0);
        #1;
        check("R2 chip erase done", {7'd0, pass_o}, 8'h01);

        // protected sector erase (R8)
        start_op(2'd1, 3'd0, 8'h00, 8'h00, 8'h08, 8'h08);
        rd(3'd3, d, p);
        check("R8 protected erase status", {p, d[6:0]}, 8'h00);
        wait_cyc(4);
        #1;
        check("R8 still busy", {7'd0, pass_o}, 8'h00);
        wait_cyc(PE);
        #1;
        check("R8 protected erase ends", {7'd0, pass_o}, 8'h01);

        // fully protected chip erase (R8)
        start_op(2'd2, 3'd0, 8'h00, 8'h00, 8'h00, 8'hFF);
        rd(3'd6, d, p);
        check("R8 chip all protected", {p, d[6:0]}, 8'h00);
        wait_cyc(PE + 2);
        #1;
        check("R8 chip protected ends", {7'd0, pass_o}, 8'h01);

        // protected program duration (R7)
        start_op(2'd0, 3'd5, 8'h00, 8'hFF, 8'h00, 8'h20);
        pulse(0);
        rd(3'd5, d, p);
        check("R7 done ignored", d, 8'h80);
        wait_cyc(PP);
        #1;
        check("R7 protected program ends", {7'd0, pass_o}, 8'h01);

        // unknown kind ignored (R12)
        start_op(2'd3, 3'd0, 8'h00, 8'hFF, 8'h00, 8'h00);
        rd(3'd0, d, p);
        check("R12 kind 3 ignored", {7'd0, p}, 8'h01);

        // reset mid operation (R12)
        start_op(2'd0, 3'd0, 8'h00, 8'hFF, 8'h00, 8'h00);
        rst_n = 1'b0;
        #1;
        check("R12 reset mid op", {7'd0, pass_o}, 8'h01);
        @(negedge clk);
        rst_n = 1'b1;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule